// File: doc/BRIEF.md
# Match-interrupt event timer

A 32-bit up-counter for scheduling events. It advances once per pulse on a slow tick-enable input, which stands for a 32768 Hz time base. Software loads a match value and asks for the counter to be zeroed. It then turns counting on and waits for an interrupt pulse. The pulse is raised on the tick that brings the count up to the match value.

Two control bits set the behaviour. A run bit gates counting. An auto-restart bit selects periodic operation, in which the counter returns to zero on every match. With auto-restart off the timer is one-shot: the handler turns the run bit off.

Zeroing the counter does not happen at the moment of the write. The request waits for the next tick, because the counter belongs to the slow time base. A status bit shows that a zeroing request is still pending, and software polls it before it enables the timer again.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the count, the match value, both control bits and the pending flag are zero, and the interrupt output is low.
- R2: The register offsets on `bus_addr` are:
  - 0x00: match value, readable and writable.
  - 0x04: live count, read-only.
  - 0x08: control, with bit 0 as the run bit and bit 1 as the auto-restart bit; all other bits read as 0.
  - 0x0C: zeroing request, write-only; it reads as 0.
  - 0x10: status, with bit 10 as the pending flag.
  - Any other offset reads as 0.
- R3: On each clock with `tick_en` high, the run bit set and no zeroing pending, the count rises by one. In every other cycle it holds its value.
- R4: A write of any data to offset 0x0C sets the pending flag. Status bit 10 reads 1 from the next cycle until the request is applied.
- R5: A pending request is applied on the next clock with `tick_en` high, whether or not the run bit is set. The count becomes 0 and the pending flag clears on that same edge, and the count does not also step on that tick.
- R6: `irq_out` is high for exactly the one cycle after a tick whose step makes the count equal to the match value. At no other time is it high.
- R7: With auto-restart off, the count steps on past the match value, and the following ticks raise no further interrupt.
- R8: With auto-restart on, the matching tick loads 0 instead of the match value. A match value of N then gives one interrupt every N ticks.
- R9: A tick that falls in the same cycle as a register write works with the values from before the write. A zeroing request written in the cycle in which an earlier request is applied leaves the pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Slow time-base pulse, one clock wide |
| irq_out | output | 1 | Single-cycle match interrupt pulse |

## Verification
Software can touch a register in the very cycle in which the slow tick acts on the counter, so bus writes and ticks can land on the same edge. The bench provokes this with one step task that can raise `tick_en` and `bus_wr` together. It uses three such cases:
- a new match value written on the tick that hits the old one;
- the run bit cleared on a counting tick;
- a zeroing request written on the tick that applies the previous one.

A scoreboard model processes the tick before the write. Its predicted interrupt bit for each edge and its predicted register readback decide pass or fail.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Register byte offsets (software-visible, fixed by the driver view)
  localparam int unsigned OFS_MATCH  = 32'h00;
  localparam int unsigned OFS_COUNT  = 32'h04;
  localparam int unsigned OFS_CTRL   = 32'h08;
  localparam int unsigned OFS_CLEAR  = 32'h0C;
  localparam int unsigned OFS_STATUS = 32'h10;

  // Bit positions decoded by software
  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_AUTO_BIT = 1;
  localparam int unsigned STAT_PEND_BIT = 10;

  typedef enum logic [2:0] {
    SEL_MATCH,
    SEL_COUNT,
    SEL_CTRL,
    SEL_CLEAR,
    SEL_STATUS,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_MATCH:  s = SEL_MATCH;
      OFS_COUNT:  s = SEL_COUNT;
      OFS_CTRL:   s = SEL_CTRL;
      OFS_CLEAR:  s = SEL_CLEAR;
      OFS_STATUS: s = SEL_STATUS;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] match_q,
  output logic          run_en,
  output logic          auto_clr,
  output logic          clr_req
);

  logic wr_match;
  logic wr_ctrl;

  assign wr_match = wr_en && (sel == SEL_MATCH);
  assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
  assign clr_req  = wr_en && (sel == SEL_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q  <= '0;
      run_en   <= 1'b0;
      auto_clr <= 1'b0;
    end else begin
      if (wr_match) match_q <= wdata;
      if (wr_ctrl) begin
        run_en   <= wdata[CTRL_RUN_BIT];
        auto_clr <= wdata[CTRL_AUTO_BIT];
      end
    end
  end

  // R2: match value only changes through its own offset
  a_r2_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_match |=> $stable(match_q));

  // R2: control bits only change through the control offset
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(run_en) && $stable(auto_clr)));

endmodule

// File: rtl/tmr_clear_flag.sv
module tmr_clear_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_req,
  input  logic tick,
  output logic pend,
  output logic clr_apply
);

  // The request is consumed by the slow time base on its next pulse
  assign clr_apply = tick && pend;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend <= 1'b0;
    else if (clr_req)   pend <= 1'b1;
    else if (clr_apply) pend <= 1'b0;
  end

  // R4: any write to the zeroing offset raises the flag
  a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> pend);

  // R4: flag stays up until a tick arrives
  a_r4_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !tick) |=> pend);

  // R5: flag drops on the applying tick unless re-armed
  a_r5_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_apply && !clr_req) |=> !pend);

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr_apply,
  input  logic         run_en,
  input  logic         auto_clr,
  input  logic [W-1:0] match_q,
  output logic [W-1:0] count_q,
  output logic         irq_q
);

  // Modulo-2^W step of the count
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  // Value loaded on a matching step
  function automatic logic [W-1:0] on_match(input logic restart,
                                            input logic [W-1:0] v);
    return restart ? {W{1'b0}} : v;
  endfunction

  logic         step_up;
  logic [W-1:0] nxt;
  logic         hit;

  assign step_up = tick && run_en && !clr_apply;
  assign nxt     = bump(count_q);
  assign hit     = step_up && (nxt == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (clr_apply)    count_q <= '0;
      else if (hit)     count_q <= on_match(auto_clr, nxt);
      else if (step_up) count_q <= nxt;
      irq_q <= hit;
    end
  end

  // R5: an applied zeroing request leaves the count at zero
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_apply |=> (count_q == {W{1'b0}}));

  // R3: no tick with run set, no zeroing: count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_apply && !(tick && run_en)) |=> $stable(count_q));

  // R6: interrupt only follows a counting tick
  a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(tick && run_en));

  // R7, R8: count after an interrupt is the match value or zero
  a_r8_irq_count: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (count_q == ($past(auto_clr) ? {W{1'b0}} : $past(match_q))));

endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              tick_en,
  output logic              irq_out
);

  reg_sel_e      sel;
  logic [DW-1:0] match_q;
  logic [DW-1:0] count_q;
  logic          run_en;
  logic          auto_clr;
  logic          clr_req;
  logic          pend;
  logic          clr_apply;

  assign sel = decode_offset(32'(bus_addr));

  tmr_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .sel      (sel),
    .wdata    (bus_wdata),
    .match_q  (match_q),
    .run_en   (run_en),
    .auto_clr (auto_clr),
    .clr_req  (clr_req)
  );

  tmr_clear_flag u_clear (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_req   (clr_req),
    .tick      (tick_en),
    .pend      (pend),
    .clr_apply (clr_apply)
  );

  tmr_core #(.W(DW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .clr_apply (clr_apply),
    .run_en    (run_en),
    .auto_clr  (auto_clr),
    .match_q   (match_q),
    .count_q   (count_q),
    .irq_q     (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_MATCH: bus_rdata = match_q;
      SEL_COUNT: bus_rdata = count_q;
      SEL_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]  = run_en;
        bus_rdata[CTRL_AUTO_BIT] = auto_clr;
      end
      SEL_STATUS: bus_rdata[STAT_PEND_BIT] = pend;
      default: bus_rdata = '0;
    endcase
  end

  // R1: interrupt is low while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !irq_out);

endmodule

// File: tb/tick_match_timer_bench.sv
module tick_match_timer_bench;

  // 250 MHz notional clock: 4 time units per period
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_en;
  logic        irq_out;

  always #2 clk = ~clk;

  tick_match_timer u_tick_match_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_en   (tick_en),
    .irq_out   (irq_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit exp_q[$];

  // Scoreboard model
  logic [31:0] m_cnt   = '0;
  logic [31:0] m_match = '0;
  bit          m_run   = 1'b0;
  bit          m_auto  = 1'b0;
  bit          m_pend  = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // One clock edge: optional tick and optional write together
  task automatic step(bit tk, bit wr, logic [4:0] a, logic [31:0] d);
    bit          apply;
    bit          e;
    logic [31:0] nx;
    @(negedge clk);
    tick_en   = tk;
    bus_wr    = wr;
    bus_addr  = a;
    bus_wdata = d;
    @(posedge clk);
    apply = tk && m_pend;
    e     = 1'b0;
    if (apply) m_cnt = '0;
    else if (tk && m_run) begin
      nx = m_cnt + 32'd1;
      if (nx == m_match) begin
        e     = 1'b1;
        m_cnt = m_auto ? 32'd0 : nx;
      end else m_cnt = nx;
    end
    if (wr && a == 5'h0C) m_pend = 1'b1;
    else if (apply)       m_pend = 1'b0;
    if (wr && a == 5'h00) m_match = d;
    if (wr && a == 5'h08) begin
      m_run  = d[0];
      m_auto = d[1];
    end
    exp_q.push_back(e);
    #1;
    tick_en = 1'b0;
    bus_wr  = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 5'h04, 32'd0);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  // Monitor: one expected interrupt bit per stepped edge, else low (R6)
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      bit e;
      e = 1'b0;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      chk("R6 irq_out", {31'd0, irq_out}, {31'd0, e});
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; tick_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq in reset", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    rd(5'h04, 32'd0, "R1 count");
    rd(5'h00, 32'd0, "R1 match");
    rd(5'h08, 32'd0, "R1 ctrl");
    rd(5'h10, 32'd0, "R1 status");

    // R2 register map
    wr(5'h00, 32'd5);
    rd(5'h00, 32'd5, "R2 match readback");
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'd3, "R2 ctrl readback");
    wr(5'h08, 32'd0);
    rd(5'h0C, 32'd0, "R2 clear reads zero");
    rd(5'h14, 32'd0, "R2 unused offset");
    wr(5'h04, 32'h1234);
    rd(5'h04, 32'd0, "R2 count read-only");

    // R3 disabled: ticks do nothing
    ticks(3);
    rd(5'h04, m_cnt, "R3 hold while stopped");
    wr(5'h08, 32'd1);
    ticks(3);
    rd(5'h04, m_cnt, "R3 count after 3 ticks");
    repeat (2) @(negedge clk);
    rd(5'h04, m_cnt, "R3 hold without tick");

    // R6 match at 5, R7 continue one-shot
    ticks(2);
    rd(5'h04, 32'd5, "R6 count at match");
    ticks(2);
    rd(5'h04, 32'd7, "R7 count past match");

    // R4 / R5 zeroing request
    wr(5'h0C, 32'hDEAD_BEEF);
    rd(5'h10, 32'd1 << 10, "R4 pending set");
    rd(5'h04, 32'd7, "R4 count unchanged before tick");
    ticks(1);
    rd(5'h04, 32'd0, "R5 count zeroed");
    rd(5'h10, 32'd0, "R5 pending dropped");
    ticks(1);
    rd(5'h04, 32'd1, "R3 resumes after zeroing");
    wr(5'h08, 32'd0);
    wr(5'h0C, 32'd0);
    ticks(1);
    rd(5'h04, 32'd0, "R5 applied while stopped");
    rd(5'h10, 32'd0, "R5 pending dropped while stopped");

    // R8 periodic with match 3
    wr(5'h00, 32'd3);
    wr(5'h08, 32'd3);
    ticks(9);
    rd(5'h04, 32'd0, "R8 count zero after third period");
    ticks(1);
    rd(5'h04, 32'd1, "R8 restart value");

    // R9 collisions
    ticks(1);
    step(1'b1, 1'b1, 5'h00, 32'd10);
    rd(5'h04, 32'd0, "R9 tick used old match");
    rd(5'h00, 32'd10, "R9 new match stored");
    step(1'b1, 1'b1, 5'h08, 32'd0);
    rd(5'h04, 32'd1, "R9 tick used old run bit");
    ticks(2);
    rd(5'h04, 32'd1, "R9 stopped afterwards");
    wr(5'h0C, 32'd0);
    step(1'b1, 1'b1, 5'h0C, 32'd0);
    rd(5'h04, 32'd0, "R9 first request applied");
    rd(5'h10, 32'd1 << 10, "R9 second request still pending");
    wr(5'h08, 32'd1);
    ticks(1);
    rd(5'h04, 32'd0, "R9 second request applied, no step");
    rd(5'h10, 32'd0, "R9 pending cleared");
    ticks(1);
    rd(5'h04, 32'd1, "R3 counting again");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule